// File: doc/BRIEF.md
# Receive Line Status with Error-Tagged RX FIFO

This block holds the characters a serial receiver has assembled and derives the line-status bits a host polls. Each stored entry carries an 8-bit character and three tags: parity error, framing error and break. A deserializer outside the block delivers characters with their error flags and a one-cycle pulse when it has seen the line held low for a full character frame. The block also watches the raw receive line level and the occupancy of the transmit path, and it reports data-ready, overrun, break, transmit-holding-empty, transmitter-empty and a global "some stored byte is bad" bit, plus the character and tags at the head of the queue.

A held break becomes exactly one queue entry, however long the line stays low; the break status stays up until the line returns high. The global error bit is driven by a running count of tagged entries, so it drops on the very cycle the last tagged byte leaves, without scanning the storage. A mode input selects queued operation (16 entries, transmit status from the transmit queue) or single-character operation (capacity of one, transmit status from the holding-register handshake).

Top module: `uart_lsr_rxfifo`

## Requirements
- R1: `data_ready` is 1 in the cycle after any edge that leaves at least one entry stored, and 0 whenever the queue is empty.
- R2: Entries leave in arrival order; `rd_pop` removes the head entry (ignored when empty). Capacity is DEPTH (16) with `fifo_mode`=1 and 1 with `fifo_mode`=0; a push in the same cycle as a pop counts against the occupancy left after the pop.
- R3: A push that finds no room is discarded and sets `overrun` on the next edge; `lsr_read` clears `overrun`, and a new discard in the same cycle wins over the clear.
- R4: `rx_head_data`, `head_pe`, `head_fe`, `head_brk` show the head entry; all four are 0 while the queue is empty.
- R5: A `brk_frame` pulse while no break is held pushes one entry with data 0x00, `head_brk`=1, `head_pe`=0, `head_fe`=0, and sets `break_ind` on the next edge.
- R6: While `break_ind` is 1, further `brk_frame` pulses push nothing; `break_ind` clears on the edge after `rx_line` is sampled 1 with no `brk_frame` in that cycle.
- R7: When `brk_frame` and `rx_valid` are both 1 in one cycle, the character from `rx_valid` is dropped and only the break rule of R5/R6 applies.
- R8: `fifo_err` is 1 exactly while at least one stored entry has any of its three tags set; a simultaneous push and pop of tagged (or of clean) entries leaves it unchanged.
- R9: With `fifo_mode`=1, `thr_empty` equals the value of `tx_fifo_empty` sampled at the previous edge.
- R10: With `fifo_mode`=0, `thr_write` clears `thr_empty` and `tsr_load` sets it; when both arrive together the write wins; otherwise the bit holds.
- R11: `tx_empty` is 1 only when the new `thr_empty` value is 1 and `tsr_busy` was 0 in the same sampled cycle, updated on the same edge as `thr_empty`.
- R12: Reset empties the queue and clears `overrun`, `break_ind`, `fifo_err` and `data_ready`, and sets `thr_empty` and `tx_empty` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode | input | 1 | 1 = queued operation, 0 = single-character operation |
| rx_valid | input | 1 | Deserializer presents a character this cycle |
| rx_data | input | 8 | Received character |
| rx_pe | input | 1 | Parity error flag for `rx_data` |
| rx_fe | input | 1 | Framing error flag for `rx_data` |
| brk_frame | input | 1 | Pulse: line seen low for a full character frame |
| rx_line | input | 1 | Raw receive line level (1 = mark) |
| rd_pop | input | 1 | Host removes the head entry |
| lsr_read | input | 1 | Host read of line status, clears overrun |
| thr_write | input | 1 | Host writes the transmit holding register |
| tsr_load | input | 1 | Holding register byte moved to the shift register |
| tx_fifo_empty | input | 1 | Transmit queue holds no byte |
| tsr_busy | input | 1 | Transmit shift register holds a character |
| rx_head_data | output | 8 | Character at the queue head |
| head_pe | output | 1 | Parity tag of the head entry |
| head_fe | output | 1 | Framing tag of the head entry |
| head_brk | output | 1 | Break tag of the head entry |
| data_ready | output | 1 | Queue holds at least one entry |
| overrun | output | 1 | A character was dropped for lack of room |
| break_ind | output | 1 | Break held on the line |
| fifo_err | output | 1 | Some stored entry carries an error tag |
| thr_empty | output | 1 | Transmit holding side is empty |
| tx_empty | output | 1 | Holding side and shift register both empty |

## Verification
The bench drives a long low line with repeated break pulses, expecting one stored break entry; a design that re-armed on each pulse would show extra 0x00 entries and a design that ignored the line level would never release `break_ind`. It fills the queue to sixteen, pushes a seventeenth with and without a simultaneous pop, and repeats at capacity one, so an off-by-one full test shows up as a lost byte or a missing overrun. It pushes and pops tagged and clean bytes in the same cycle and drains the queue past the last tagged entry, where a miscounted tally leaves `fifo_err` stuck or drops it early. It also collides `thr_write` with `tsr_load` and `brk_frame` with `rx_valid`, where the wrong priority flips `thr_empty` or queues a stray character.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;

    parameter int unsigned RX_DATA_W = 8;

    typedef struct packed {
        logic                 brk;
        logic                 fe;
        logic                 pe;
        logic [RX_DATA_W-1:0] data;
    } rx_ent_t;

endpackage

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
    import uart_lsr_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cap_one,
    input  logic                           push,
    input  rx_ent_t                        wr_ent,
    input  logic                           pop,
    output rx_ent_t                        head_ent,
    output logic [$clog2(DEPTH+1)-1:0]     fill,
    output logic                           push_ok,
    output logic                           pop_ok,
    output logic                           drop
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);
    localparam logic [CNT_W-1:0] CAP_FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CAP_ONE  = CNT_W'(1);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    rx_ent_t  mem [DEPTH];

    logic [CNT_W-1:0] left_after_pop;
    logic [CNT_W-1:0] cap;

    always_comb begin
        st_d           = st_q;
        cap            = cap_one ? CAP_ONE : CAP_FULL;
        pop_ok         = pop && (st_q.cnt != '0);
        left_after_pop = st_q.cnt - CNT_W'(pop_ok);
        push_ok        = push && (left_after_pop < cap);
        drop           = push && !push_ok;

        if (pop_ok) begin
            st_d.rd_ptr = (st_q.rd_ptr == LAST) ? '0 : st_q.rd_ptr + 1'b1;
        end
        if (push_ok) begin
            st_d.wr_ptr = (st_q.wr_ptr == LAST) ? '0 : st_q.wr_ptr + 1'b1;
        end
        st_d.cnt = left_after_pop + CNT_W'(push_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[st_q.wr_ptr] <= wr_ent;
        end
    end

    assign head_ent = (st_q.cnt != '0) ? mem[st_q.rd_ptr] : '0;
    assign fill     = st_q.cnt;

endmodule

// File: rtl/err_tally.sv
module err_tally #(
    parameter int unsigned DEPTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_bad,
    input  logic out_bad,
    output logic any_bad
);
    localparam int unsigned TW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [TW-1:0] tally;
    } tally_st_t;

    tally_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case ({in_bad, out_bad})
            2'b10:   st_d.tally = st_q.tally + 1'b1;
            2'b01:   st_d.tally = st_q.tally - 1'b1;
            default: st_d.tally = st_q.tally;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign any_bad = (st_q.tally != '0);

endmodule

// File: rtl/brk_tracker.sv
module brk_tracker
    import uart_lsr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 brk_frame,
    input  logic                 rx_line,
    input  logic                 rx_valid,
    input  logic [RX_DATA_W-1:0] rx_data,
    input  logic                 rx_pe,
    input  logic                 rx_fe,
    output logic                 push,
    output rx_ent_t              push_ent,
    output logic                 held
);
    typedef struct packed {
        logic hold;
    } brk_st_t;

    brk_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        push     = 1'b0;
        push_ent = '0;
        if (brk_frame) begin
            push         = !st_q.hold;
            push_ent.brk = 1'b1;
            st_d.hold    = 1'b1;
        end else begin
            push          = rx_valid;
            push_ent.data = rx_data;
            push_ent.pe   = rx_pe;
            push_ent.fe   = rx_fe;
            if (rx_line) begin
                st_d.hold = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held = st_q.hold;

endmodule

// File: rtl/line_flags.sv
module line_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_mode,
    input  logic thr_write,
    input  logic tsr_load,
    input  logic tx_fifo_empty,
    input  logic tsr_busy,
    input  logic drop,
    input  logic lsr_read,
    output logic thr_empty,
    output logic tx_empty,
    output logic overrun
);
    typedef struct packed {
        logic thre;
        logic temt;
        logic ovr;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fifo_mode) begin
            st_d.thre = tx_fifo_empty;
        end else if (thr_write) begin
            st_d.thre = 1'b0;
        end else if (tsr_load) begin
            st_d.thre = 1'b1;
        end
        st_d.temt = st_d.thre && !tsr_busy;
        if (drop) begin
            st_d.ovr = 1'b1;
        end else if (lsr_read) begin
            st_d.ovr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{thre: 1'b1, temt: 1'b1, ovr: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign thr_empty = st_q.thre;
    assign tx_empty  = st_q.temt;
    assign overrun   = st_q.ovr;

endmodule

// File: rtl/uart_lsr_rxfifo.sv
module uart_lsr_rxfifo
    import uart_lsr_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fifo_mode,
    input  logic                 rx_valid,
    input  logic [RX_DATA_W-1:0] rx_data,
    input  logic                 rx_pe,
    input  logic                 rx_fe,
    input  logic                 brk_frame,
    input  logic                 rx_line,
    input  logic                 rd_pop,
    input  logic                 lsr_read,
    input  logic                 thr_write,
    input  logic                 tsr_load,
    input  logic                 tx_fifo_empty,
    input  logic                 tsr_busy,
    output logic [RX_DATA_W-1:0] rx_head_data,
    output logic                 head_pe,
    output logic                 head_fe,
    output logic                 head_brk,
    output logic                 data_ready,
    output logic                 overrun,
    output logic                 break_ind,
    output logic                 fifo_err,
    output logic                 thr_empty,
    output logic                 tx_empty
);
    localparam int unsigned CNT_W = $clog2(DEPTH+1);

    logic             push_req;
    rx_ent_t          push_ent;
    rx_ent_t          head_ent;
    logic [CNT_W-1:0] fill_cnt;
    logic             push_ok;
    logic             pop_ok;
    logic             drop;

    brk_tracker u_brk (
        .clk      (clk),
        .rst_n    (rst_n),
        .brk_frame(brk_frame),
        .rx_line  (rx_line),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_pe    (rx_pe),
        .rx_fe    (rx_fe),
        .push     (push_req),
        .push_ent (push_ent),
        .held     (break_ind)
    );

    rx_tag_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_one (!fifo_mode),
        .push    (push_req),
        .wr_ent  (push_ent),
        .pop     (rd_pop),
        .head_ent(head_ent),
        .fill    (fill_cnt),
        .push_ok (push_ok),
        .pop_ok  (pop_ok),
        .drop    (drop)
    );

    err_tally #(.DEPTH(DEPTH)) u_tally (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_bad (push_ok && (push_ent.pe || push_ent.fe || push_ent.brk)),
        .out_bad(pop_ok && (head_ent.pe || head_ent.fe || head_ent.brk)),
        .any_bad(fifo_err)
    );

    line_flags u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .fifo_mode    (fifo_mode),
        .thr_write    (thr_write),
        .tsr_load     (tsr_load),
        .tx_fifo_empty(tx_fifo_empty),
        .tsr_busy     (tsr_busy),
        .drop         (drop),
        .lsr_read     (lsr_read),
        .thr_empty    (thr_empty),
        .tx_empty     (tx_empty),
        .overrun      (overrun)
    );

    assign rx_head_data = head_ent.data;
    assign head_pe      = head_ent.pe;
    assign head_fe      = head_ent.fe;
    assign head_brk     = head_ent.brk;
    assign data_ready   = (fill_cnt != '0);

endmodule

// File: rtl/uart_lsr_rxfifo_chk.sv
module uart_lsr_rxfifo_chk #(
    parameter int unsigned DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       fifo_mode,
    input logic                       rx_valid,
    input logic                       brk_frame,
    input logic                       rx_line,
    input logic                       rd_pop,
    input logic                       thr_write,
    input logic                       tx_fifo_empty,
    input logic                       push_req,
    input logic [$clog2(DEPTH+1)-1:0] fill_cnt,
    input logic                       head_pe,
    input logic                       head_fe,
    input logic                       head_brk,
    input logic                       data_ready,
    input logic                       overrun,
    input logic                       break_ind,
    input logic                       fifo_err,
    input logic                       thr_empty,
    input logic                       tx_empty
);
    localparam int unsigned CNT_W = $clog2(DEPTH+1);

    a_r1_ready_after_push: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !brk_frame && !rd_pop) |=> data_ready);

    a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= CNT_W'(DEPTH));

    a_r3_overrun_on_full: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_mode && push_req && !rd_pop && fill_cnt == CNT_W'(DEPTH)) |=> overrun);

    a_r4_empty_head_clean: assert property (@(posedge clk) disable iff (!rst_n)
        !data_ready |-> !(head_pe || head_fe || head_brk));

    a_r5_break_sets: assert property (@(posedge clk) disable iff (!rst_n)
        brk_frame |=> break_ind);

    a_r6_break_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (break_ind && !rx_line) |=> break_ind);

    a_r6_break_release: assert property (@(posedge clk) disable iff (!rst_n)
        (break_ind && rx_line && !brk_frame) |=> !break_ind);

    a_r8_err_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_err |-> data_ready);

    a_r9_thre_follows: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_mode |=> (thr_empty == $past(tx_fifo_empty)));

    a_r10_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_mode && thr_write) |=> !thr_empty);

    a_r11_temt_implies_thre: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> thr_empty);

endmodule

bind uart_lsr_rxfifo uart_lsr_rxfifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_mode    (fifo_mode),
    .rx_valid     (rx_valid),
    .brk_frame    (brk_frame),
    .rx_line      (rx_line),
    .rd_pop       (rd_pop),
    .thr_write    (thr_write),
    .tx_fifo_empty(tx_fifo_empty),
    .push_req     (push_req),
    .fill_cnt     (fill_cnt),
    .head_pe      (head_pe),
    .head_fe      (head_fe),
    .head_brk     (head_brk),
    .data_ready   (data_ready),
    .overrun      (overrun),
    .break_ind    (break_ind),
    .fifo_err     (fifo_err),
    .thr_empty    (thr_empty),
    .tx_empty     (tx_empty)
);

// File: tb/uart_lsr_rxfifo_tb.sv
module uart_lsr_rxfifo_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_mode = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_pe = 1'b0;
    logic       rx_fe = 1'b0;
    logic       brk_frame = 1'b0;
    logic       rx_line = 1'b1;
    logic       rd_pop = 1'b0;
    logic       lsr_read = 1'b0;
    logic       thr_write = 1'b0;
    logic       tsr_load = 1'b0;
    logic       tx_fifo_empty = 1'b1;
    logic       tsr_busy = 1'b0;

    logic [7:0] rx_head_data;
    logic       head_pe, head_fe, head_brk;
    logic       data_ready, overrun, break_ind, fifo_err, thr_empty, tx_empty;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // reference state
    logic [10:0] mq[$];   // {brk, fe, pe, data}
    bit m_ovr = 0, m_brk = 0, m_thre = 1, m_temt = 1;

    uart_lsr_rxfifo #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_pe(rx_pe), .rx_fe(rx_fe), .brk_frame(brk_frame),
        .rx_line(rx_line), .rd_pop(rd_pop), .lsr_read(lsr_read),
        .thr_write(thr_write), .tsr_load(tsr_load), .tx_fifo_empty(tx_fifo_empty),
        .tsr_busy(tsr_busy), .rx_head_data(rx_head_data), .head_pe(head_pe),
        .head_fe(head_fe), .head_brk(head_brk), .data_ready(data_ready),
        .overrun(overrun), .break_ind(break_ind), .fifo_err(fifo_err),
        .thr_empty(thr_empty), .tx_empty(tx_empty)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit m_any_err();
        foreach (mq[i]) if (mq[i][10:8] != 3'b000) return 1;
        return 0;
    endfunction

    task automatic model_step();
        int cap;
        bit do_pop, push;
        logic [10:0] ent;
        cap = fifo_mode ? DEPTH : 1;
        do_pop = rd_pop && (mq.size() != 0);
        if (brk_frame) begin
            push = !m_brk;
            ent = {3'b100, 8'h00};
            m_brk = 1;
        end else begin
            push = rx_valid;
            ent = {1'b0, rx_fe, rx_pe, rx_data};
            if (rx_line) m_brk = 0;
        end
        if (do_pop) void'(mq.pop_front());
        if (lsr_read) m_ovr = 0;
        if (push) begin
            if (mq.size() < cap) mq.push_back(ent);
            else m_ovr = 1;
        end
        if (fifo_mode) m_thre = tx_fifo_empty;
        else if (thr_write) m_thre = 0;
        else if (tsr_load) m_thre = 1;
        m_temt = m_thre && !tsr_busy;
    endtask

    task automatic compare_all();
        logic [10:0] h;
        h = (mq.size() != 0) ? mq[0] : 11'h0;
        chk("R1 data_ready", data_ready, mq.size() != 0);
        chk("R2 head data order", rx_head_data, h[7:0]);
        chk("R4 head pe", head_pe, h[8]);
        chk("R4 head fe", head_fe, h[9]);
        chk("R4 head brk", head_brk, h[10]);
        chk("R3 overrun", overrun, m_ovr);
        chk("R5 break_ind", break_ind, m_brk);
        chk("R8 fifo_err", fifo_err, m_any_err());
        chk(fifo_mode ? "R9 thr_empty" : "R10 thr_empty", thr_empty, m_thre);
        chk("R11 tx_empty", tx_empty, m_temt);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        model_step();
        compare_all();
        rx_valid = 0; brk_frame = 0; rd_pop = 0; lsr_read = 0;
        thr_write = 0; tsr_load = 0; rx_pe = 0; rx_fe = 0;
    endtask

    task automatic send(input logic [7:0] d, input bit pe, input bit fe);
        rx_valid = 1; rx_data = d; rx_pe = pe; rx_fe = fe;
        tick();
    endtask

    task automatic pop_one();
        rd_pop = 1;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 reset data_ready", data_ready, 0);
        chk("R12 reset overrun", overrun, 0);
        chk("R12 reset break_ind", break_ind, 0);
        chk("R12 reset fifo_err", fifo_err, 0);
        chk("R12 reset thr_empty", thr_empty, 1);
        chk("R12 reset tx_empty", tx_empty, 1);
        rst_n = 1;

        // R1 R2: clean bytes in order
        for (int i = 0; i < 5; i++) send(8'h30 + 8'(i), 0, 0);
        for (int i = 0; i < 6; i++) pop_one();

        // R2 R3: fill to capacity, overflow, clear
        for (int i = 0; i < DEPTH; i++) send(8'h80 + 8'(i), 0, 0);
        send(8'hEE, 0, 0);
        chk("R3 overrun after full push", overrun, 1);
        rx_valid = 1; rx_data = 8'hDD; rd_pop = 1; tick();
        lsr_read = 1; tick();
        chk("R3 overrun cleared", overrun, 0);
        lsr_read = 1; rx_valid = 1; rx_data = 8'hCC; tick();
        chk("R3 drop beats clear", overrun, 1);
        lsr_read = 1; tick();
        for (int i = 0; i < DEPTH + 1; i++) pop_one();

        // R8 R4: tagged entries
        send(8'h01, 0, 0); send(8'h02, 1, 0); send(8'h03, 0, 0); send(8'h04, 0, 1);
        pop_one(); pop_one();
        // R8: push tagged while popping clean -> still tagged
        rx_valid = 1; rx_data = 8'h05; rx_pe = 1; rd_pop = 1; tick();
        // R8: push clean while popping tagged
        rx_valid = 1; rx_data = 8'h06; rd_pop = 1; tick();
        for (int i = 0; i < 4; i++) pop_one();
        chk("R8 err cleared when drained", fifo_err, 0);

        // R5 R6 R7: break handling
        rx_line = 0;
        repeat (3) tick();
        brk_frame = 1; tick();
        chk("R5 break entry tag", head_brk, 1);
        chk("R5 break entry data", rx_head_data, 0);
        for (int i = 0; i < 4; i++) begin brk_frame = 1; tick(); end
        brk_frame = 1; rx_valid = 1; rx_data = 8'h77; tick();
        chk("R6 single break entry", data_ready, 1);
        pop_one();
        chk("R6 no extra break entries", data_ready, 0);
        chk("R6 break held while low", break_ind, 1);
        rx_line = 1; brk_frame = 1; rx_valid = 1; rx_data = 8'h66; tick();
        chk("R7 char dropped under break", data_ready, 0);
        tick();
        chk("R6 break released on mark", break_ind, 0);
        rx_line = 0; brk_frame = 1; tick();
        chk("R5 new break after release", head_brk, 1);
        rx_line = 1; tick();
        pop_one();

        // R2 R10 R11: single-character mode
        fifo_mode = 0;
        send(8'h11, 0, 0);
        send(8'h22, 0, 0);
        chk("R2 capacity one", overrun, 1);
        rx_valid = 1; rx_data = 8'h33; rd_pop = 1; tick();
        chk("R2 push with pop at capacity one", rx_head_data, 8'h33);
        lsr_read = 1; rd_pop = 1; tick();
        thr_write = 1; tick();
        chk("R10 write clears", thr_empty, 0);
        tsr_busy = 1; tsr_load = 1; tick();
        chk("R11 busy shift register", tx_empty, 0);
        thr_write = 1; tsr_load = 1; tick();
        chk("R10 write wins", thr_empty, 0);
        tsr_load = 1; tsr_busy = 0; tick();
        chk("R11 both empty", tx_empty, 1);
        tick();

        // R9 R11: queued mode transmit status
        fifo_mode = 1;
        tx_fifo_empty = 0; tick();
        chk("R9 tx queue occupied", thr_empty, 0);
        tx_fifo_empty = 1; tsr_busy = 1; tick();
        chk("R11 shift busy", tx_empty, 0);
        tsr_busy = 0; tick();

        // mixed traffic
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            rx_valid = (r < 55);
            rx_data = 8'($urandom);
            rx_pe = ($urandom_range(0, 9) == 0);
            rx_fe = ($urandom_range(0, 9) == 0);
            rd_pop = ($urandom_range(0, 99) < 45);
            brk_frame = ($urandom_range(0, 99) < 4);
            if ($urandom_range(0, 19) == 0) rx_line = ~rx_line;
            lsr_read = ($urandom_range(0, 9) == 0);
            thr_write = ($urandom_range(0, 4) == 0);
            tsr_load = ($urandom_range(0, 4) == 0);
            tx_fifo_empty = $urandom_range(0, 1) != 0;
            tsr_busy = $urandom_range(0, 1) != 0;
            if ($urandom_range(0, 199) == 0) fifo_mode = ~fifo_mode;
            tick();
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule